// File: doc/BRIEF.md
# Ratiometric Resistive-Sensor Readout Arithmetic Unit

This block sits behind a multiplexed ADC that digitises four voltages in turn: the voltage across a resistive transducer, the voltage across an on-chip reference resistor in series with it, and the base-emitter voltage of one bipolar transistor at two bias levels. All four codes are ratios to the ADC's own reference voltage. The block combines them so that this reference voltage cancels. It returns the transducer resistance, the power dissipated in the transducer, and the die temperature.

A `start` pulse begins a frame. The block drives `chan_sel` through slots 0 to 3 and takes one code per slot when `adc_valid` is high. It then forms a digitally weighted bandgap term B from the two base-emitter codes. From B it computes the temperature. The temperature is used to correct the reference resistor for drift. The block then computes resistance and power. All three quotients go through one shared sequential divider. The states are: IDLE (wait for start), ACQ (capture four codes), BGAP (form B and the base-emitter difference), T_ISSUE/T_WAIT (temperature divide), RCOMP (compensated reference resistor), R_ISSUE/R_WAIT (resistance divide), P_ISSUE/P_WAIT (power divide), and FINISH (publish results and pulse done).

The transitions are:
- IDLE→ACQ on start.
- ACQ→BGAP after the fourth code.
- BGAP→T_ISSUE.
- T_ISSUE→FINISH if B is zero, otherwise T_ISSUE→T_WAIT.
- T_WAIT→RCOMP when the divider finishes.
- RCOMP→R_ISSUE.
- R_ISSUE→P_ISSUE if m2 is zero, otherwise R_ISSUE→R_WAIT.
- R_WAIT→P_ISSUE when the divider finishes.
- P_ISSUE→FINISH if the power divisor is zero, otherwise P_ISSUE→P_WAIT.
- P_WAIT→FINISH when the divider finishes.
- FINISH→IDLE.

Top module: `rdo_sensor_readout`

## Requirements
- R1: After reset, `chan_sel`, `done`, `err` and all three results are zero.
- R2: During a frame, `chan_sel` equals the index of the slot being filled. Slot 0 holds the transducer code (m1), slot 1 the reference-resistor code (m2), slot 2 the base-emitter code at bias 1 (m3) and slot 3 the base-emitter code at bias 2 (m4). `chan_sel` advances only on a cycle with `adc_valid` high, and the code on that cycle is captured. `adc_valid` while idle is ignored and `chan_sel` stays 0.
- R3: Each 24-bit signed code, with full scale ±1, becomes a fixed-point value with 16 fractional bits by an arithmetic right shift of 7. A product mul(a,b) is (a*b) arithmetically shifted right by 16. The bandgap term is B = m3 + mul(alpha, m3 - m4), which equals (1+alpha)·m3 - alpha·m4.
- R4: Temperature = div(mul(K, m3 - m4), B). K is the scale-constant input.
- R5: The compensated reference resistor is Rc = Rref0 + mul(Rref0, mul(tc, T - T0)). Resistance = div(mul(Rc, m1), m2).
- R6: Power = div(mul(mul(Vbg, Vbg), mul(m1, m2)), mul(Rc, mul(B, B))).
- R7: div(n,d) is computed as follows. Take |n|·2^16 / |d|, truncated. Give it the sign of n xor the sign of d. Then saturate it to a 32-bit signed range: positive to 0x7FFFFFFF, negative to -2^31.
- R8: If m2 is zero, resistance is 0x7FFFFFFF and `err` is 1, while temperature and power are computed normally. A zero power divisor likewise gives power 0x7FFFFFFF and sets `err`.
- R9: If B is zero, all three results are 0x7FFFFFFF and `err` is 1.
- R10: `done` is high for exactly one cycle per frame. The results and `err` change only together with `done` and hold until the next frame's `done`. `err` reflects only the latest frame.
- R11: A `start` pulse during a frame has no effect on the slot sequence or on that frame's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| adc_valid | input | 1 | ADC code is valid this cycle |
| adc_code | input | 24 | Signed ADC code, ratio to ADC reference |
| chan_sel | output | 2 | Multiplexer slot being converted |
| cal_alpha | input | 32 | Bandgap weighting coefficient, Q16 signed |
| cal_vbg | input | 32 | Bandgap voltage, Q16 |
| cal_rref0 | input | 32 | Reference resistor at trim temperature, Q16 |
| cal_tc | input | 32 | Reference resistor temperature coefficient, Q16 |
| cal_kt | input | 32 | Temperature scale constant, Q16 |
| cal_t0 | input | 32 | Trim temperature, Q16 |
| res_ohm | output | 32 | Transducer resistance, Q16 |
| res_pwr | output | 32 | Transducer power, Q16 |
| res_temp | output | 32 | Die temperature, Q16 |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | A zero divisor was met in the last frame |

## Verification
A wrong temperature quotient does not stay local. It passes through the compensated resistor into both resistance and power in the same frame, so one miscompare at `done` usually shows in several outputs at once. A slot counter that skips or repeats shows on `chan_sel` at the very next sample, before any result exists. A sticky or stale error state or divider state shows at the following frame's `done`, as a wrong `err` or a value left over from the previous frame. The divide and saturation corners are driven so that they hit both the positive and the negative saturation limits.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    localparam int FX_W   = 48;
    localparam int FX_F   = 16;
    localparam int RES_W  = 32;
    localparam int CODE_W = 24;

    typedef logic signed [FX_W-1:0]  fx_t;
    typedef logic signed [RES_W-1:0] res_t;

    localparam res_t RES_MAX = {1'b0, {(RES_W-1){1'b1}}};

    typedef enum logic [3:0] {
        ST_IDLE, ST_ACQ, ST_BGAP, ST_T_ISSUE, ST_T_WAIT, ST_RCOMP,
        ST_R_ISSUE, ST_R_WAIT, ST_P_ISSUE, ST_P_WAIT, ST_FINISH
    } ctl_state_t;

    // fixed-point product, floor rounding, kept to FX_W bits
    function automatic fx_t fx_mul(fx_t a, fx_t b);
        logic signed [2*FX_W-1:0] wide;
        wide = a * b;
        wide = wide >>> FX_F;
        return wide[FX_W-1:0];
    endfunction
endpackage

// File: rtl/rdo_slot_capture.sv
module rdo_slot_capture #(
    parameter int SLOTS  = 4,
    parameter int CODE_W = 24,
    localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          begin_frame,
    input  logic                          adc_valid,
    input  logic [CODE_W-1:0]             adc_code,
    output logic [SEL_W-1:0]              chan_sel,
    output logic                          cap_done,
    output logic [SLOTS-1:0][CODE_W-1:0]  codes
);
    logic             active_q;
    logic [SEL_W-1:0] slot_q;
    logic             done_q;
    logic [SLOTS-1:0][CODE_W-1:0] codes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            done_q   <= 1'b0;
            codes_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (begin_frame) begin
                    active_q <= 1'b1;
                    slot_q   <= '0;
                end
            end else if (adc_valid) begin
                codes_q[slot_q] <= adc_code;
                if (slot_q == SEL_W'(SLOTS-1)) begin
                    active_q <= 1'b0;
                    slot_q   <= '0;
                    done_q   <= 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign chan_sel = slot_q;
    assign cap_done = done_q;
    assign codes    = codes_q;

    // R2: the slot only moves on a valid strobe
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !adc_valid) |=> $stable(chan_sel));
endmodule

// File: rtl/rdo_divider.sv
module rdo_divider #(
    parameter int NUM_W = 48,
    parameter int FRAC  = 16,
    parameter int OUT_W = 32,
    localparam int DVD_W = NUM_W + FRAC,
    localparam int CNT_W = $clog2(DVD_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic signed [NUM_W-1:0] num,
    input  logic signed [NUM_W-1:0] den,
    output logic                    busy,
    output logic                    done,
    output logic signed [OUT_W-1:0] quo
);
    localparam logic [DVD_W-1:0] LIM_POS = {{(DVD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic [DVD_W-1:0] LIM_NEG = LIM_POS + 1'b1;

    logic [DVD_W-1:0] dvd_q, quo_q;
    logic [NUM_W-1:0] rem_q, dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             neg_q, busy_q, done_q;

    logic [NUM_W:0]   trial;
    logic             fits;
    logic [NUM_W-1:0] num_mag, den_mag;

    assign num_mag = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
    assign den_mag = den[NUM_W-1] ? NUM_W'(-den) : NUM_W'(den);
    assign trial   = {rem_q, dvd_q[DVD_W-1]};
    assign fits    = trial >= {1'b0, dsr_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q <= '0; quo_q <= '0; rem_q <= '0; dsr_q <= '0;
            cnt_q <= '0; neg_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                dvd_q  <= {num_mag, {FRAC{1'b0}}};
                dsr_q  <= den_mag;
                rem_q  <= '0;
                quo_q  <= '0;
                neg_q  <= num[NUM_W-1] ^ den[NUM_W-1];
                cnt_q  <= CNT_W'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? NUM_W'(trial - {1'b0, dsr_q}) : NUM_W'(trial);
                quo_q <= {quo_q[DVD_W-2:0], fits};
                dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (!neg_q)
            quo = (quo_q > LIM_POS) ? OUT_W'(LIM_POS) : OUT_W'(quo_q);
        else if (quo_q > LIM_NEG)
            quo = {1'b1, {(OUT_W-1){1'b0}}};
        else
            quo = OUT_W'(~quo_q[OUT_W-1:0] + 1'b1);
    end

    assign busy = busy_q;
    assign done = done_q;

    // R7: a quotient is only presented after a full run
    p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: rtl/rdo_sensor_readout.sv
module rdo_sensor_readout
    import rdo_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int SEL_W = $clog2(SLOTS),
    localparam int CODE_SHIFT = CODE_W - 1 - FX_F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     adc_valid,
    input  logic [CODE_W-1:0]        adc_code,
    output logic [SEL_W-1:0]         chan_sel,
    input  logic signed [RES_W-1:0]  cal_alpha,
    input  logic signed [RES_W-1:0]  cal_vbg,
    input  logic signed [RES_W-1:0]  cal_rref0,
    input  logic signed [RES_W-1:0]  cal_tc,
    input  logic signed [RES_W-1:0]  cal_kt,
    input  logic signed [RES_W-1:0]  cal_t0,
    output logic signed [RES_W-1:0]  res_ohm,
    output logic signed [RES_W-1:0]  res_pwr,
    output logic signed [RES_W-1:0]  res_temp,
    output logic                     done,
    output logic                     err
);
    ctl_state_t state_q, state_d;

    logic                         cap_start, cap_done;
    logic [SLOTS-1:0][CODE_W-1:0] codes;
    fx_t                          m_fx [SLOTS];

    fx_t  b_q, dv_q, t_q, rc_q;
    res_t t_w, r_w, p_w;
    logic err_w;
    res_t out_t_q, out_r_q, out_p_q;
    logic out_err_q, done_q;

    logic div_go, div_busy, div_done;
    fx_t  div_num, div_den, p_num, p_den;
    res_t div_quo;

    fx_t alpha_fx, vbg_fx, rref0_fx, tc_fx, kt_fx, t0_fx;
    assign alpha_fx = fx_t'(cal_alpha);
    assign vbg_fx   = fx_t'(cal_vbg);
    assign rref0_fx = fx_t'(cal_rref0);
    assign tc_fx    = fx_t'(cal_tc);
    assign kt_fx    = fx_t'(cal_kt);
    assign t0_fx    = fx_t'(cal_t0);

    assign cap_start = (state_q == ST_IDLE) && start;

    rdo_slot_capture #(.SLOTS(SLOTS), .CODE_W(CODE_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .begin_frame(cap_start),
        .adc_valid(adc_valid), .adc_code(adc_code),
        .chan_sel(chan_sel), .cap_done(cap_done), .codes(codes)
    );

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_scale
        assign m_fx[gi] = fx_t'($signed(codes[gi])) >>> CODE_SHIFT;
    end

    rdo_divider #(.NUM_W(FX_W), .FRAC(FX_F), .OUT_W(RES_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_quo)
    );

    // operand selection for the shared divider
    always_comb begin
        p_num   = fx_mul(fx_mul(vbg_fx, vbg_fx), fx_mul(m_fx[0], m_fx[1]));
        p_den   = fx_mul(rc_q, fx_mul(b_q, b_q));
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        unique case (state_q)
            ST_T_ISSUE: begin
                div_num = fx_mul(kt_fx, dv_q);
                div_den = b_q;
                div_go  = (b_q != '0);
            end
            ST_R_ISSUE: begin
                div_num = fx_mul(rc_q, m_fx[0]);
                div_den = m_fx[1];
                div_go  = (m_fx[1] != '0);
            end
            ST_P_ISSUE: begin
                div_num = p_num;
                div_den = p_den;
                div_go  = (p_den != '0);
            end
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ACQ;
            ST_ACQ:     if (cap_done) state_d = ST_BGAP;
            ST_BGAP:    state_d = ST_T_ISSUE;
            ST_T_ISSUE: state_d = (b_q == '0) ? ST_FINISH : ST_T_WAIT;
            ST_T_WAIT:  if (div_done) state_d = ST_RCOMP;
            ST_RCOMP:   state_d = ST_R_ISSUE;
            ST_R_ISSUE: state_d = (m_fx[1] == '0) ? ST_P_ISSUE : ST_R_WAIT;
            ST_R_WAIT:  if (div_done) state_d = ST_P_ISSUE;
            ST_P_ISSUE: state_d = (p_den == '0) ? ST_FINISH : ST_P_WAIT;
            ST_P_WAIT:  if (div_done) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0; dv_q <= '0; t_q <= '0; rc_q <= '0;
            t_w <= '0; r_w <= '0; p_w <= '0; err_w <= 1'b0;
            out_t_q <= '0; out_r_q <= '0; out_p_q <= '0;
            out_err_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) err_w <= 1'b0;
                ST_BGAP: begin
                    dv_q <= m_fx[2] - m_fx[3];
                    b_q  <= m_fx[2] + fx_mul(alpha_fx, m_fx[2] - m_fx[3]);
                end
                ST_T_ISSUE: if (b_q == '0) begin
                    t_w <= RES_MAX; r_w <= RES_MAX; p_w <= RES_MAX;
                    err_w <= 1'b1;
                end
                ST_T_WAIT: if (div_done) begin
                    t_w <= div_quo;
                    t_q <= fx_t'(div_quo);
                end
                ST_RCOMP:
                    rc_q <= rref0_fx + fx_mul(rref0_fx, fx_mul(tc_fx, t_q - t0_fx));
                ST_R_ISSUE: if (m_fx[1] == '0) begin
                    r_w <= RES_MAX;
                    err_w <= 1'b1;
                end
                ST_R_WAIT: if (div_done) r_w <= div_quo;
                ST_P_ISSUE: if (p_den == '0) begin
                    p_w <= RES_MAX;
                    err_w <= 1'b1;
                end
                ST_P_WAIT: if (div_done) p_w <= div_quo;
                ST_FINISH: begin
                    out_t_q   <= t_w;
                    out_r_q   <= r_w;
                    out_p_q   <= p_w;
                    out_err_q <= err_w;
                    done_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign res_temp = out_t_q;
    assign res_ohm  = out_r_q;
    assign res_pwr  = out_p_q;
    assign err      = out_err_q;
    assign done     = done_q;

    // R10: strobe lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: results move only with the strobe
    p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_ohm) || !$stable(res_pwr) || !$stable(res_temp) |-> done);
    // R7: the controller never launches into a running divider
    p_go_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy);
    // R8: a flagged frame carries at least one saturated result
    p_err_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (res_ohm == RES_MAX || res_pwr == RES_MAX || res_temp == RES_MAX));
    // R11: a frame in progress is not restarted
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ && start && !adc_valid) |=> $stable(chan_sel));
endmodule

// File: tb/rdo_sensor_readout_tb_top.sv
module rdo_sensor_readout_tb_top;
    typedef struct packed {
        logic [23:0] m1, m2, m3, m4;
        logic [31:0] alpha, vbg, rref0, tc, kt, t0;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{24'd3355443, 24'd2516582, 24'd5452595, 24'd4613734,
          32'd393216, 32'd78643, 32'd6553600, 32'd131, 32'd196608000, 32'd19660800},
        '{24'd838861, 24'd4194304, 24'd4613734, 24'd5452595,
          32'd32768, 32'd78643, 32'd6553600, 32'd131, 32'd65536000, 32'd19660800},
        '{24'd3355443, 24'd128, 24'd5452595, 24'd4613734,
          32'd393216, 32'd78643, 32'd6553600, 32'd131, 32'd196608000, 32'd19660800},
        '{-24'sd3355443, 24'd128, 24'd5452595, 24'd4613734,
          32'd393216, 32'd78643, 32'd6553600, 32'd131, 32'd196608000, 32'd19660800}
    };
    localparam longint SATP = 64'sd2147483647;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, adc_valid = 1'b0;
    logic [23:0] adc_code = '0;
    logic [1:0]  chan_sel;
    logic signed [31:0] cal_alpha, cal_vbg, cal_rref0, cal_tc, cal_kt, cal_t0;
    logic signed [31:0] res_ohm, res_pwr, res_temp;
    logic done, err;
    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    rdo_sensor_readout dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_valid(adc_valid),
        .adc_code(adc_code), .chan_sel(chan_sel),
        .cal_alpha(cal_alpha), .cal_vbg(cal_vbg), .cal_rref0(cal_rref0),
        .cal_tc(cal_tc), .cal_kt(cal_kt), .cal_t0(cal_t0),
        .res_ohm(res_ohm), .res_pwr(res_pwr), .res_temp(res_temp),
        .done(done), .err(err)
    );

    function automatic longint cv(logic [23:0] c);
        return longint'($signed(c)) >>> 7;
    endfunction
    function automatic longint mulf(longint a, longint b);
        return (a * b) >>> 16;
    endfunction
    function automatic longint divf(longint n, longint d);
        longint nm, dm, q;
        if (d == 0) return SATP;
        nm = (n < 0) ? -n : n;
        dm = (d < 0) ? -d : d;
        q  = (nm <<< 16) / dm;
        if ((n < 0) == (d < 0)) return (q > SATP) ? SATP : q;
        return (q > SATP + 1) ? -(SATP + 1) : -q;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(vec_t v, output longint et, output longint er,
                         output longint ep, output bit ee);
        longint m1, m2, m3, m4, b, rc, pd;
        m1 = cv(v.m1); m2 = cv(v.m2); m3 = cv(v.m3); m4 = cv(v.m4);
        b  = m3 + mulf(longint'($signed(v.alpha)), m3 - m4);
        ee = 1'b0;
        if (b == 0) begin
            et = SATP; er = SATP; ep = SATP; ee = 1'b1;
            return;
        end
        et = divf(mulf(longint'($signed(v.kt)), m3 - m4), b);
        rc = longint'($signed(v.rref0))
           + mulf(longint'($signed(v.rref0)), mulf(longint'($signed(v.tc)), et - longint'($signed(v.t0))));
        if (m2 == 0) begin er = SATP; ee = 1'b1; end
        else er = divf(mulf(rc, m1), m2);
        pd = mulf(rc, mulf(b, b));
        if (pd == 0) begin ep = SATP; ee = 1'b1; end
        else ep = divf(mulf(mulf(longint'($signed(v.vbg)), longint'($signed(v.vbg))), mulf(m1, m2)), pd);
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        if (!done) check({tag, " done timeout"}, 0, 1);
    endtask

    // one frame; mid_start pulses start again after slot 1
    task automatic run_frame(vec_t v, int gap, bit mid_start);
        logic [23:0] cd [4];
        cd[0] = v.m1; cd[1] = v.m2; cd[2] = v.m3; cd[3] = v.m4;
        cal_alpha = v.alpha; cal_vbg = v.vbg; cal_rref0 = v.rref0;
        cal_tc = v.tc; cal_kt = v.kt; cal_t0 = v.t0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int s = 0; s < 4; s++) begin
            repeat (gap) @(negedge clk);
            check("R2 chan_sel before capture", chan_sel, s);
            adc_valid = 1'b1; adc_code = cd[s];
            @(negedge clk);
            adc_valid = 1'b0; adc_code = 24'h5A5A5A;
            if (mid_start && s == 1) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R11 chan_sel after start in frame", chan_sel, 2);
            end
        end
        wait_done("R10");
    endtask

    task automatic check_results(vec_t v, string tag);
        longint et, er, ep;
        bit ee;
        model(v, et, er, ep, ee);
        check({tag, " R4 temperature"}, res_temp, et);
        check({tag, " R5 resistance"}, res_ohm, er);
        check({tag, " R6 power"}, res_pwr, ep);
        check({tag, " R8 err"}, err, ee);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        vec_t v;
        longint hold_r;
        cal_alpha = '0; cal_vbg = '0; cal_rref0 = '0; cal_tc = '0; cal_kt = '0; cal_t0 = '0;
        repeat (3) @(negedge clk);
        check("R1 chan_sel reset", chan_sel, 0);
        check("R1 done reset", done, 0);
        check("R1 err reset", err, 0);
        check("R1 res_ohm reset", res_ohm, 0);
        check("R1 res_pwr reset", res_pwr, 0);
        check("R1 res_temp reset", res_temp, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: valid while idle is ignored
        adc_valid = 1'b1; adc_code = 24'h123456;
        repeat (3) @(negedge clk);
        adc_valid = 1'b0;
        check("R2 idle valid leaves chan_sel", chan_sel, 0);
        check("R2 idle valid gives no done", done, 0);

        // vector table: R3..R7
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i], i % 3, 1'b0);
            check_results(VECS[i], $sformatf("vec%0d R3 R7", i));
        end

        // R8: m2 zero
        v = VECS[0]; v.m2 = 24'd0;
        run_frame(v, 1, 1'b0);
        check_results(v, "m2zero");
        check("R8 resistance saturated", res_ohm, SATP);

        // R9: B zero
        v = VECS[0]; v.m3 = 24'd0; v.m4 = 24'd0;
        run_frame(v, 0, 1'b0);
        check("R9 temperature saturated", res_temp, SATP);
        check("R9 resistance saturated", res_ohm, SATP);
        check("R9 power saturated", res_pwr, SATP);
        check("R9 err", err, 1);

        // R10: err cleared by a clean frame; strobe single; results held
        run_frame(VECS[1], 2, 1'b0);
        check("R10 err cleared", err, 0);
        hold_r = res_ohm;
        @(negedge clk);
        check("R10 done single cycle", done, 0);
        repeat (5) @(negedge clk);
        check("R10 result held", res_ohm, hold_r);

        // R11: start during capture ignored
        run_frame(VECS[0], 1, 1'b1);
        check_results(VECS[0], "R11 restart ignored");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule